// File: doc/BRIEF.md
# CEC Follower Acknowledge Generator

This block runs next to a consumer-electronics-control bit receiver and acknowledges received blocks on the shared open-drain line. The receiver supplies a decoded bit position and a header/data flag. For header blocks it also supplies the 4-bit destination field, which is the low nibble of the header. In the acknowledge bit of each block, the initiator pulls the line low. The generator detects that falling edge and, when an acknowledge is due, holds the line low itself until the point used for a transmitted logical 0.

A header whose destination equals the programmed logical address is always acknowledged. The match is remembered for the rest of the frame. Data blocks of a matched frame are acknowledged unless the suppress control is set. Frames addressed elsewhere are never acknowledged. The release point is taken from the same 3-bit low-time field that the transmitter uses. No private copy of that field is kept. All time limits are cycle counts derived from a parameter that gives the number of sampling cycles per 0.05 ms.

Top module: `cec_ack_gen`

## Requirements
- R1: While reset is active, and whenever no acknowledge is in progress, `cec_drv_n` is 1 (line released).
- R2: In a header block's acknowledge slot, if `hdr_addr` equals `log_addr`, the line is pulled low regardless of `ack_dis`.
- R3: In a data block's acknowledge slot, after a matching header in the same frame and with `ack_dis` = 0, the line is pulled low.
- R4: With `ack_dis` = 1, a data block's acknowledge slot leaves the line released.
- R5: After a header whose `hdr_addr` differs from `log_addr`, neither that header nor the following data blocks are acknowledged.
- R6: Acknowledge logic is armed only while `bit_idx` equals 9. Falling edges at bit positions 0 to 8 never cause the line to be driven.
- R7: Driving starts no later than 7 × CYC_PER_50US cycles (0.35 ms) after the initiator's falling edge at the `cec_in` pin.
- R8: The driven low period lasts exactly 30 × CYC_PER_50US − `lo_sel` cycles, where `lo_sel` (0 to 7) is the shared low-time field. The limit is therefore 1.5 ms minus up to 7 cycles.
- R9: Assertion of `rx_err` or `rx_abort` releases the line on the next clock edge and clears the stored match, so later data blocks of that frame are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cec_in | input | 1 | Sensed level of the CEC line |
| bit_idx | input | 4 | Receiver's bit position within the current block (9 = acknowledge bit) |
| hdr_blk | input | 1 | 1 while the current block is a header block |
| hdr_addr | input | 4 | Destination field (low nibble) of the header block |
| log_addr | input | 4 | Programmed logical address |
| ack_dis | input | 1 | 1 suppresses data-block acknowledges |
| lo_sel | input | 3 | Shared low-time field; cycles subtracted from the 1.5 ms low period |
| rx_err | input | 1 | Receiver bit-error strobe |
| rx_abort | input | 1 | Receiver frame-abort strobe |
| cec_drv_n | output | 1 | Active-low open-drain enable; 0 pulls the line low |

## Verification
On every cycle, the assertions check the following. A drive only ever starts from the acknowledge bit. The line had actually fallen before the drive began. A header drive implies an address match, and a data drive implies acknowledges are enabled. An error or abort releases the line one edge later. No low period exceeds 1.5 ms. Only the bench scenarios can show the rest: the exact low width for each `lo_sel` value, the start latency, the absence of drives for mismatched or suppressed blocks, and the clearing of the stored match across later data blocks of a frame.

// File: rtl/cec_ack_pkg.sv
package cec_ack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DRIVE = 2'd2,
        ST_DONE  = 2'd3
    } ack_st_e;

    typedef struct packed {
        ack_st_e st;
        logic    match;
    } ack_regs_t;

endpackage

// File: rtl/cec_ack_sync.sv
module cec_ack_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic fall_o
);
    logic meta_d, meta_q;
    logic sync_d, sync_q;
    logic prev_d, prev_q;

    always_comb begin
        meta_d = line_i;
        sync_d = meta_q;
        prev_d = sync_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= meta_d;
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign fall_o = prev_q && !sync_q;
endmodule

// File: rtl/cec_ack_decide.sv
module cec_ack_decide #(
    parameter int AW = 4
) (
    input  logic          hdr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] la_i,
    input  logic          match_q_i,
    input  logic          ack_dis_i,
    output logic          ack_o,
    output logic          match_o
);
    logic hit;

    always_comb begin
        hit = (addr_i == la_i);
        if (hdr_i) begin
            match_o = hit;
            ack_o   = hit;
        end else begin
            match_o = match_q_i;
            ack_o   = match_q_i && !ack_dis_i;
        end
    end
endmodule

// File: rtl/cec_ack_timer.sv
module cec_ack_timer #(
    parameter int CYC_PER_50US = 8,
    parameter int SELW         = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [SELW-1:0] sel_i,
    output logic            expire_o
);
    localparam int LOW_CYC = 30 * CYC_PER_50US;
    localparam int CW      = $clog2(LOW_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] hold;

    always_comb begin
        hold     = CW'(LOW_CYC) - CW'(sel_i);
        cnt_d    = run_i ? cnt_q + CW'(1) : '0;
        expire_o = run_i && (cnt_q == hold - CW'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cec_ack_gen.sv
module cec_ack_gen #(
    parameter int CYC_PER_50US = 8,
    parameter int AW           = 4,
    parameter int IDXW         = 4,
    parameter int BLK_BITS     = 10,
    parameter int SELW         = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cec_in,
    input  logic [IDXW-1:0] bit_idx,
    input  logic            hdr_blk,
    input  logic [AW-1:0]   hdr_addr,
    input  logic [AW-1:0]   log_addr,
    input  logic            ack_dis,
    input  logic [SELW-1:0] lo_sel,
    input  logic            rx_err,
    input  logic            rx_abort,
    output logic            cec_drv_n
);
    import cec_ack_pkg::*;

    localparam logic [IDXW-1:0] ACK_IDX = IDXW'(BLK_BITS - 1);

    ack_regs_t r_d, r_q;
    logic      fall;
    logic      ack_due;
    logic      match_new;
    logic      expire;
    logic      in_slot;
    logic      driving;

    cec_ack_sync i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (cec_in),
        .fall_o (fall)
    );

    cec_ack_decide #(.AW(AW)) i_decide (
        .hdr_i     (hdr_blk),
        .addr_i    (hdr_addr),
        .la_i      (log_addr),
        .match_q_i (r_q.match),
        .ack_dis_i (ack_dis),
        .ack_o     (ack_due),
        .match_o   (match_new)
    );

    assign driving = (r_q.st == ST_DRIVE);

    cec_ack_timer #(.CYC_PER_50US(CYC_PER_50US), .SELW(SELW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (driving),
        .sel_i    (lo_sel),
        .expire_o (expire)
    );

    always_comb begin
        r_d     = r_q;
        in_slot = (bit_idx == ACK_IDX);
        case (r_q.st)
            ST_IDLE: begin
                if (in_slot) r_d.st = ST_ARMED;
            end
            ST_ARMED: begin
                if (!in_slot) begin
                    r_d.st = ST_IDLE;
                end else if (fall) begin
                    r_d.match = match_new;
                    r_d.st    = ack_due ? ST_DRIVE : ST_DONE;
                end
            end
            ST_DRIVE: begin
                if (expire) r_d.st = ST_DONE;
            end
            default: begin
                if (!in_slot) r_d.st = ST_IDLE;
            end
        endcase
        if (rx_err || rx_abort) begin
            r_d.st    = ST_DONE;
            r_d.match = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.match <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cec_drv_n = !driving;
endmodule

// File: rtl/cec_ack_chk.sv
module cec_ack_chk #(
    parameter int CYC_PER_50US = 8,
    parameter int AW           = 4,
    parameter int IDXW         = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cec_in,
    input logic [IDXW-1:0] bit_idx,
    input logic            hdr_blk,
    input logic [AW-1:0]   hdr_addr,
    input logic [AW-1:0]   log_addr,
    input logic            ack_dis,
    input logic            rx_err,
    input logic            rx_abort,
    input logic            cec_drv_n
);
    localparam int LOW_CYC = 30 * CYC_PER_50US;

    int low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          low_run <= 0;
        else if (!cec_drv_n) low_run <= low_run + 1;
        else                 low_run <= 0;
    end

    AST_ARM_ONLY_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cec_drv_n) |-> ($past(bit_idx) == IDXW'(9)));  // R6

    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cec_drv_n) |-> ($past(cec_in, 3) == 1'b0));  // R7

    AST_HDR_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cec_drv_n) && $past(hdr_blk)) |-> ($past(hdr_addr) == $past(log_addr)));  // R2

    AST_DATA_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cec_drv_n) && !$past(hdr_blk)) |-> !$past(ack_dis));  // R4

    AST_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_err || rx_abort) |=> cec_drv_n);  // R9

    AST_LOW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        !cec_drv_n |-> (low_run < LOW_CYC));  // R8
endmodule

bind cec_ack_gen cec_ack_chk #(
    .CYC_PER_50US(CYC_PER_50US),
    .AW          (AW),
    .IDXW        (IDXW)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cec_in    (cec_in),
    .bit_idx   (bit_idx),
    .hdr_blk   (hdr_blk),
    .hdr_addr  (hdr_addr),
    .log_addr  (log_addr),
    .ack_dis   (ack_dis),
    .rx_err    (rx_err),
    .rx_abort  (rx_abort),
    .cec_drv_n (cec_drv_n)
);

// File: tb/test_cec_ack_gen.sv
module test_cec_ack_gen;
    localparam int CYC     = 8;
    localparam int LOW     = 30 * CYC;
    localparam int LAT_MAX = 7 * CYC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bit_idx = 4'd0;
    logic       hdr_blk = 1'b0;
    logic [3:0] hdr_addr = 4'd0;
    logic [3:0] log_addr = 4'd5;
    logic       ack_dis = 1'b0;
    logic [2:0] lo_sel = 3'd0;
    logic       rx_err = 1'b0;
    logic       rx_abort = 1'b0;
    logic       snd_low = 1'b0;
    logic       cec_drv_n;
    logic       cec_in;

    assign cec_in = !(snd_low || !cec_drv_n);

    always #4 clk = ~clk;

    cec_ack_gen #(.CYC_PER_50US(CYC)) i_cec_ack_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cec_in    (cec_in),
        .bit_idx   (bit_idx),
        .hdr_blk   (hdr_blk),
        .hdr_addr  (hdr_addr),
        .log_addr  (log_addr),
        .ack_dis   (ack_dis),
        .lo_sel    (lo_sel),
        .rx_err    (rx_err),
        .rx_abort  (rx_abort),
        .cec_drv_n (cec_drv_n)
    );

    typedef struct {
        int    width;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   reported = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    // Driver: plays one block and pushes the expected acknowledge width.
    task automatic run_block(input bit hdr, input logic [3:0] addr, input int exp_w,
                             input string tag, input int inj);
        hdr_blk  = hdr;
        hdr_addr = addr;
        for (int b = 0; b < 9; b++) begin
            @(negedge clk) bit_idx = 4'(b);
            repeat (2) @(negedge clk);
            snd_low = 1'b1;
            repeat (4) @(negedge clk);
            snd_low = 1'b0;
            repeat (2) @(negedge clk);
        end
        q.push_back('{exp_w, tag});
        @(negedge clk) bit_idx = 4'd9;
        repeat (5) @(negedge clk);
        snd_low = 1'b1;
        if (inj != 0) begin
            for (int g = 0; g < 50 && cec_drv_n; g++) @(negedge clk);
            repeat (10) @(negedge clk);
            if (inj == 1) rx_err = 1'b1;
            else          rx_abort = 1'b1;
            @(negedge clk);
            rx_err   = 1'b0;
            rx_abort = 1'b0;
        end
        repeat (90) @(negedge clk);
        snd_low = 1'b0;
        repeat (LOW) @(negedge clk);
        bit_idx = 4'd0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: measures each acknowledge slot and compares with the queue.
    initial begin
        int  w = 0, lat = -1, t = -1, outside = 0;
        bit  in_slot = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && bit_idx == 4'd9) begin
                in_slot = 1;
                if (snd_low && t < 0) t = 0;
                else if (t >= 0) t++;
                if (!cec_drv_n) begin
                    if (lat < 0) lat = t;
                    w++;
                end
            end else begin
                if (rst_n && !cec_drv_n) outside++;
                if (in_slot) begin
                    in_slot = 0;
                    if (q.size() == 0) begin
                        check(0, "scoreboard underflow", 0, 1);
                    end else begin
                        e = q.pop_front();
                        check(w == e.width, e.tag, w, e.width);
                        if (e.width > 0)
                            check(lat >= 0 && lat <= LAT_MAX, "R7 start latency", lat, LAT_MAX);
                        check(outside == 0, "R6 drive outside ack bit", outside, 0);
                    end
                    w = 0; lat = -1; t = -1; outside = 0;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cec_drv_n == 1'b1, "R1 released in reset", int'(cec_drv_n), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cec_drv_n == 1'b1, "R1 released when idle", int'(cec_drv_n), 1);

        lo_sel = 3'd0; ack_dis = 1'b0;
        run_block(1, 4'd5, LOW, "R2 header match", 0);
        run_block(0, 4'd0, LOW, "R3 data ack", 0);
        lo_sel = 3'd7;
        run_block(0, 4'd0, LOW - 7, "R8 low width sel 7", 0);
        ack_dis = 1'b1;
        run_block(0, 4'd0, 0, "R4 data suppressed", 0);
        lo_sel = 3'd3;
        run_block(1, 4'd5, LOW - 3, "R2 header acked with suppress set", 0);
        run_block(0, 4'd0, 0, "R4 data suppressed again", 0);
        ack_dis = 1'b0;
        run_block(1, 4'd9, 0, "R5 header mismatch", 0);
        run_block(0, 4'd0, 0, "R5 data after mismatch", 0);
        lo_sel = 3'd0;
        run_block(1, 4'd5, 11, "R9 error cuts drive", 1);
        run_block(0, 4'd0, 0, "R9 match cleared by error", 0);
        run_block(1, 4'd5, LOW, "R2 header match again", 0);
        run_block(0, 4'd0, 11, "R9 abort cuts drive", 2);
        run_block(0, 4'd0, 0, "R9 match cleared by abort", 0);
        log_addr = 4'hA; lo_sel = 3'd5;
        run_block(1, 4'hA, LOW - 5, "R2 new logical address", 0);
        run_block(0, 4'd0, LOW - 5, "R3 data ack new address", 0);
        repeat (5) @(negedge clk);
        check(cec_drv_n == 1'b1, "R1 released after traffic", int'(cec_drv_n), 1);
        check(q.size() == 0, "scoreboard drained", q.size(), 0);
        report();
        $finish;
    end
endmodule